// File: doc/BRIEF.md
# Packed Element-Width Vector Adder

This block carries out one vector addition across a register file of 64-bit registers. A start pulse hands it a vector length, an element-width selection, a base register for each of the two sources and the destination, and a per-operand scalar flag. It then steps through the elements one per clock. For each element it reads both source registers through two combinational read ports and writes the result through a write port that has byte enables.

Narrow elements of 8, 16 or 32 bits are packed into consecutive registers. Element 0 sits in the least significant bits of the base register. Each element wraps inside its own width, so no carry crosses into a neighbouring element. In the widening mode, only the sources are narrow. Each result is then the full 64-bit sum of the two zero-extended source elements, and it goes into its own destination register. A flag pulses one cycle after the last write.

Top module: `vec_lane_adder`

## Requirements
- R1: In the packed mode, each element result is the sum of the two source elements modulo 2^W. Example: with W=8 and VL=2, sources 0x43ff and 0x1220 give 0x551f.
- R2: The element width W is selected by ew_sel: 0 gives 64, 1 gives 32, 2 gives 16 and 3 gives 8. For a vector operand, element i lives in register base+(i*W)/64 at bit offset (i*W)%64, so element 0 holds the least significant bits of the base register.
- R3: A packed-mode write enables only the W/8 bytes that the element covers. Every other bit of the destination register keeps its prior value, including the upper half of a last register that is only partly filled.
- R4: In the widening mode (src_only_w=1), element i's result is the 64-bit sum of the zero-extended source elements. It is written with all eight byte enables to register d_base+i. Example: with W=8 and VL=2, 0x43ff and 0x1220 give 0x11f and then 0x55.
- R5: With ew_sel=0, each element fills one whole register, at register index base+i.
- R6: With VL=0, no write occurs, and done pulses in the cycle after the start is taken.
- R7: With d_scal=1, exactly one element (element 0) is written, whatever VL is.
- R8: A source marked scalar supplies the W-bit field at bit 0 of its base register to every element.
- R9: Writes occur on consecutive cycles, the first in the cycle after the start is taken. busy is high during the writes. done is a one-cycle pulse in the cycle after the last write. After reset, busy, done and wr_en are low.
- R10: A start raised while busy or done is high is ignored, and the operation in flight is unaffected.
- R11: Register indices wrap modulo the register count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| vl | input | VLW | Vector length |
| ew_sel | input | 2 | Element width: 0=64, 1=32, 2=16, 3=8 |
| src_only_w | input | 1 | Widening mode: width applies to sources only |
| d_base | input | AW | Destination base register |
| a_base | input | AW | First source base register |
| b_base | input | AW | Second source base register |
| d_scal | input | 1 | Destination is scalar |
| a_scal | input | 1 | First source is scalar |
| b_scal | input | 1 | Second source is scalar |
| busy | output | 1 | Element writes in progress |
| done | output | 1 | Completion pulse |
| a_addr | output | AW | First source read address |
| a_data | input | 64 | First source read data, same cycle |
| b_addr | output | AW | Second source read address |
| b_data | input | 64 | Second source read data, same cycle |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | AW | Register write address |
| wr_data | output | 64 | Register write data |
| wr_be | output | 8 | Byte enables for the write |

## Verification
The assertions assume that the read ports return data in the same cycle as the address and that the operation inputs are valid whenever start is high. The bench's register model answers reads combinationally and applies each enabled byte on the following edge. The sweep keeps the source ranges and the destination range apart, so a write never changes a value that a later element reads. The ignored-start case changes the base inputs while the block is busy, to show that they were latched at the start.

// File: rtl/vec_lane_adder.sv
module vec_lane_adder #(
  parameter int AW  = 5,
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  input  logic [1:0]     ew_sel,
  input  logic           src_only_w,
  input  logic [AW-1:0]  d_base,
  input  logic [AW-1:0]  a_base,
  input  logic [AW-1:0]  b_base,
  input  logic           d_scal,
  input  logic           a_scal,
  input  logic           b_scal,
  output logic           busy,
  output logic           done,
  output logic [AW-1:0]  a_addr,
  input  logic [63:0]    a_data,
  output logic [AW-1:0]  b_addr,
  input  logic [63:0]    b_data,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [63:0]    wr_data,
  output logic [7:0]     wr_be
);
  localparam int PW = VLW + 6;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic [VLW-1:0] idx, vl_q;
  logic [1:0]     ew_q;
  logic           sw_q, ds_q, as_q, bs_q;
  logic [AW-1:0]  db_q, ab_q, bb_q;

  logic           last;
  logic [2:0]     lg;
  logic [PW-1:0]  step, pa, pb, pd;
  logic [63:0]    emask, a_el, b_el, sum;
  logic [7:0]     bmask;

  assign last = ds_q || (idx == vl_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      vl_q <= '0;
      ew_q <= '0;
      sw_q <= 1'b0;
      ds_q <= 1'b0;
      as_q <= 1'b0;
      bs_q <= 1'b0;
      db_q <= '0;
      ab_q <= '0;
      bb_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          vl_q <= vl;
          ew_q <= ew_sel;
          sw_q <= src_only_w;
          ds_q <= d_scal;
          as_q <= a_scal;
          bs_q <= b_scal;
          db_q <= d_base;
          ab_q <= a_base;
          bb_q <= b_base;
          idx  <= '0;
          st   <= (vl == '0) ? S_FIN : S_RUN;
        end
        S_RUN: begin
          if (last) st <= S_FIN;
          else      idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign lg    = 3'd6 - {1'b0, ew_q};
  assign step  = PW'(idx) << lg;
  assign pa    = as_q ? '0 : step;
  assign pb    = bs_q ? '0 : step;
  assign pd    = sw_q ? (PW'(idx) << 6) : step;

  assign emask = (ew_q == 2'd0) ? '1 : ((64'd1 << (7'd64 >> ew_q)) - 64'd1);

  always_comb begin
    case (ew_q)
      2'd0:    bmask = 8'hff;
      2'd1:    bmask = 8'h0f;
      2'd2:    bmask = 8'h03;
      default: bmask = 8'h01;
    endcase
  end

  assign a_addr  = ab_q + AW'(pa >> 6);
  assign b_addr  = bb_q + AW'(pb >> 6);
  assign a_el    = (a_data >> pa[5:0]) & emask;
  assign b_el    = (b_data >> pb[5:0]) & emask;
  assign sum     = a_el + b_el;

  assign wr_en   = (st == S_RUN);
  assign wr_addr = db_q + AW'(pd >> 6);
  assign wr_data = sw_q ? sum : ((sum & emask) << pd[5:0]);
  assign wr_be   = sw_q ? 8'hff : (bmask << pd[5:3]);

  assign busy    = (st == S_RUN);
  assign done    = (st == S_FIN);
endmodule

module vec_lane_adder_chk #(
  parameter int AW  = 5,
  parameter int VLW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [VLW-1:0] vl,
  input logic           d_scal,
  input logic [AW-1:0]  d_base,
  input logic           busy,
  input logic           done,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [7:0]     wr_be
);
  logic idle;
  assign idle = !busy && !done;

  // R6
  vl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && vl == '0) |=> (done && !wr_en));

  // R9
  first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && vl != '0) |=> (wr_en && wr_addr == $past(d_base)));

  // R7
  scalar_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && vl != '0 && d_scal) |=> wr_en ##1 (done && !wr_en));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !wr_en));

  // R3
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_be) == 1 || $countones(wr_be) == 2 ||
               $countones(wr_be) == 4 || $countones(wr_be) == 8));

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind vec_lane_adder vec_lane_adder_chk #(.AW(AW), .VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .d_scal(d_scal),
  .d_base(d_base), .busy(busy), .done(done), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_be(wr_be)
);

// File: tb/vec_lane_adder_tb_top.sv
module vec_lane_adder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       start = 1'b0;
  logic [6:0] vl = '0;
  logic [1:0] ew_sel = '0;
  logic       src_only_w = 1'b0;
  logic [4:0] d_base = '0, a_base = '0, b_base = '0;
  logic       d_scal = 1'b0, a_scal = 1'b0, b_scal = 1'b0;
  logic       busy, done, wr_en;
  logic [4:0] a_addr, b_addr, wr_addr;
  logic [63:0] a_data, b_data, wr_data;
  logic [7:0] wr_be;

  logic [63:0] rf [32];
  assign a_data = rf[a_addr];
  assign b_data = rf[b_addr];

  int errors = 0;
  int checks = 0;
  logic [63:0] seed = 64'h0123_4567_89ab_cdef;

  vec_lane_adder dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .ew_sel(ew_sel),
    .src_only_w(src_only_w), .d_base(d_base), .a_base(a_base), .b_base(b_base),
    .d_scal(d_scal), .a_scal(a_scal), .b_scal(b_scal), .busy(busy), .done(done),
    .a_addr(a_addr), .a_data(a_data), .b_addr(b_addr), .b_data(b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic fill_rf();
    for (int r = 0; r < 32; r++) begin
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      rf[r] = seed;
    end
  endtask

  task automatic clear_rf();
    for (int r = 0; r < 32; r++) rf[r] = '0;
  endtask

  task automatic run_op(input string req, input logic [1:0] ew, input logic sw,
                        input logic [6:0] vlv, input logic [4:0] d, input logic [4:0] a,
                        input logic [4:0] b, input logic ds, input logic as_, input logic bs,
                        input bit extra_start);
    logic [63:0] ex [32];
    logic [63:0] m, av, bv, s;
    int w, nw, cyc, nwr, pa, pb, pd, r, nbad, badr;
    bit got, order_ok, pend;
    logic [4:0] p_addr;
    logic [63:0] p_data;
    logic [7:0] p_be;
    ex = rf;
    w = 64 >> ew;
    m = (ew == 2'd0) ? '1 : ((64'd1 << w) - 64'd1);
    nw = (vlv == 0) ? 0 : (ds ? 1 : int'(vlv));
    for (int e = 0; e < nw; e++) begin
      pa = as_ ? 0 : e * w;
      pb = bs ? 0 : e * w;
      av = (rf[(a + pa / 64) % 32] >> (pa % 64)) & m;
      bv = (rf[(b + pb / 64) % 32] >> (pb % 64)) & m;
      s = av + bv;
      if (sw) ex[(d + e) % 32] = s;
      else begin
        pd = e * w;
        r = (d + pd / 64) % 32;
        ex[r] = (ex[r] & ~(m << (pd % 64))) | ((s & m) << (pd % 64));
      end
    end
    @(negedge clk);
    vl = vlv; ew_sel = ew; src_only_w = sw;
    d_base = d; a_base = a; b_base = b;
    d_scal = ds; a_scal = as_; b_scal = bs;
    start = 1'b1;
    cyc = 0; nwr = 0; got = 0; order_ok = 1; pend = 0;
    p_addr = '0; p_data = '0; p_be = '0;
    while (!got && cyc < 200) begin
      @(posedge clk);
      if (pend)
        for (int k = 0; k < 8; k++)
          if (p_be[k]) rf[p_addr][8*k +: 8] = p_data[8*k +: 8];
      pend = 0;
      @(negedge clk);
      cyc++;
      start = extra_start && cyc < 3;
      if (extra_start) begin
        d_base = d + 5'd3; a_base = a + 5'd1; b_base = b + 5'd2; vl = 7'd1;
      end
      if (wr_en) begin
        nwr++;
        if (cyc != nwr || !busy) order_ok = 0;
        pend = 1; p_addr = wr_addr; p_data = wr_data; p_be = wr_be;
      end
      if (done) got = 1;
    end
    start = 1'b0;
    chk(got && cyc == nw + 1 && order_ok, req, "done latency", 64'(cyc), 64'(nw + 1));
    chk(nwr == nw, req, "write count", 64'(nwr), 64'(nw));
    nbad = 0; badr = 0;
    for (int k = 0; k < 32; k++)
      if (rf[k] !== ex[k]) begin
        if (nbad == 0) badr = k;
        nbad++;
      end
    chk(nbad == 0, req, $sformatf("register file r%0d", badr), rf[badr], ex[badr]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int vls[6] = '{0, 1, 2, 3, 5, 8};
    string tag;
    clear_rf();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !wr_en, "R9", "reset outputs",
        {61'd0, busy, done, wr_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: byte lanes wrap independently
    clear_rf(); rf[5] = 64'h43ff; rf[9] = 64'h1220;
    run_op("R1", 2'd3, 1'b0, 7'd2, 5'd1, 5'd5, 5'd9, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rf[1] == 64'h551f, "R1", "ew8 packed sum", rf[1], 64'h551f);

    // R4: widening mode
    clear_rf(); rf[5] = 64'h43ff; rf[9] = 64'h1220;
    run_op("R4", 2'd3, 1'b1, 7'd2, 5'd1, 5'd5, 5'd9, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rf[1] == 64'h11f, "R4", "widened element 0", rf[1], 64'h11f);
    chk(rf[2] == 64'h55, "R4", "widened element 1", rf[2], 64'h55);

    // R2 / R3: 32-bit packing, partial last register
    clear_rf();
    rf[9] = 64'h1000_1000_f000_1220; rf[10] = 64'h2000_2000_8000_1111;
    rf[5] = 64'h0000_0000_8000_43ff; rf[6] = 64'h9000_0000_0000_2223;
    rf[2] = 64'h0000_0001_0000_0002;
    run_op("R2", 2'd1, 1'b0, 7'd3, 5'd1, 5'd5, 5'd9, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rf[1] == 64'h1000_1000_7000_561f, "R2", "ew32 full register", rf[1],
        64'h1000_1000_7000_561f);
    chk(rf[2] == 64'h0000_0001_8000_3334, "R3", "upper half preserved", rf[2],
        64'h0000_0001_8000_3334);

    // R6: zero length
    fill_rf();
    run_op("R6", 2'd0, 1'b0, 7'd0, 5'd1, 5'd5, 5'd9, 1'b0, 1'b0, 1'b0, 1'b0);

    // R7: scalar destination stops after one element
    fill_rf();
    run_op("R7", 2'd0, 1'b0, 7'd3, 5'd1, 5'd5, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0);

    // R8: scalar source broadcast
    clear_rf();
    rf[1] = 64'habcd_0000_0000_0000;
    rf[5] = 64'h0003_0002_0001_1000;
    rf[9] = 64'h0000_0030_0020_0010;
    run_op("R8", 2'd2, 1'b0, 7'd3, 5'd1, 5'd5, 5'd9, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(rf[1] == 64'habcd_1030_1020_1010, "R8", "broadcast scalar", rf[1],
        64'habcd_1030_1020_1010);

    // R10: start while busy is ignored
    fill_rf();
    run_op("R10", 2'd0, 1'b0, 7'd2, 5'd1, 5'd5, 5'd9, 1'b0, 1'b0, 1'b0, 1'b1);
    fill_rf();
    run_op("R10", 2'd3, 1'b0, 7'd1, 5'd1, 5'd5, 5'd9, 1'b0, 1'b0, 1'b0, 1'b1);

    // R11: register index wrap
    fill_rf();
    run_op("R11", 2'd3, 1'b1, 7'd4, 5'd30, 5'd4, 5'd12, 1'b0, 1'b0, 1'b0, 1'b0);
    fill_rf();
    run_op("R11", 2'd0, 1'b0, 7'd3, 5'd31, 5'd4, 5'd12, 1'b0, 1'b0, 1'b0, 1'b0);

    // sweep: widths, modes, lengths, scalar flags
    for (int ew = 0; ew < 4; ew++)
      for (int sw = 0; sw < 2; sw++)
        for (int vi = 0; vi < 6; vi++)
          for (int sc = 0; sc < 8; sc++) begin
            if (sc[1] || sc[2]) tag = "R8";
            else if (sw == 1) tag = "R4";
            else if (ew == 0) tag = "R5";
            else tag = "R2";
            fill_rf();
            run_op(tag, 2'(ew), 1'(sw), 7'(vls[vi]), 5'd24, 5'd8, 5'd16,
                   sc[0], sc[1], sc[2], 1'b0);
          end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule